// File: doc/BRIEF.md
# Fault-Tolerant Polyphase Code Correlator

This block correlates a stream of signed received samples against a stored pseudo-noise chip sequence. The stored sequence acts as the tap weights of a matched filter, one chip of +1 or -1 per tap. The filter is split into four interleaved polyphase branches. Each branch sums its own chip-weighted samples over one window of 32 accepted samples. The four partial correlations are then fused into one full-scale correlation value, which is compared against a programmable threshold to flag code acquisition.

When the input is slowly varying, each branch result scaled by four estimates the same full correlation. A timing fault in one branch appears as a rare error of large magnitude. A plain sum passes that error straight through. The block therefore also offers two robust fusion rules. The first is a median of the four branch results. The second is one clipped-residual refinement step that starts from the median and limits how much any single branch can pull the estimate. A two-bit mode input picks the rule, so the same data can be compared under all three rules. The mode, the clip limit and the threshold are expected to stay steady from the first sample of a window until its result appears.

Top module: `pn_robust_correlator`

## Requirements
- R1: While reset is held, and until the first result, out_valid and out_detect are 0 and out_corr is 0. The code register resets to all zeros, which means every chip is -1.
- R2: Bit i of the code register is the chip for sample i of a window, with bit value 1 meaning +1 and bit value 0 meaning -1. A code_load pulse replaces the whole register, and the new chips apply to samples accepted on later clock edges, including the rest of a window already in progress.
- R3: Sample i of a window (i = 0..31, counted over accepted samples) goes to branch i mod 4. Each branch result is the sum of chip times sample over its 8 samples.
- R4: Only cycles with in_valid high advance the window. out_valid is high for exactly one cycle, on the third rising edge after the edge that accepted sample 31, and never in two consecutive cycles.
- R5: In mode 0 and mode 3 (sum), out_corr is the sum of the four branch results.
- R6: In mode 1 (median), with the branch results sorted ascending as a<=b<=c<=d, out_corr = 2*(b+c), which is the mean of the two middle values scaled by four.
- R7: In mode 2 (clipped), with S = b+c and each residual r_p = 2*y_p - S clipped to the range [-2k, +2k] (k = clip_k, unsigned), out_corr = 2*S + floor(sum of clipped residuals / 2).
- R8: out_detect is high in exactly the out_valid cycles where |out_corr| >= det_thresh (unsigned). An equal value counts as a detection.
- R9: out_corr keeps its last value between results.
- R10: In mode 2 with clip_k = 0, out_corr equals the mode 1 result for the same window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 8 | Signed received sample |
| code_load | input | 1 | Load strobe for the chip register |
| code_word | input | 32 | Chip sequence, bit i is the chip for sample i |
| fuse_mode | input | 2 | 0 or 3 sum, 1 median, 2 clipped |
| clip_k | input | 16 | Clip limit k for the clipped mode |
| det_thresh | input | 19 | Unsigned detection threshold on the magnitude |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_corr | output | 19 | Signed fused correlation, held between results |
| out_detect | output | 1 | Acquisition pulse, coincident with out_valid |

## Verification
Constant samples under an all-ones code make the three rules agree, which isolates chip sign handling and threshold equality. A window in which one branch alone receives much larger samples separates the rules. The sum absorbs the outlier, the median ignores it, and the clipped step moves only by the clip limit. Random samples, codes, clip limits and valid gaps check the branch routing and the floor rounding of odd residual sums. A code reload in mid-window, together with the all-minus code left by reset, checks when new chips take effect.

// File: rtl/pn_corr_pkg.sv
`timescale 1ns/1ps
package pn_corr_pkg;

  // fusion rule selector; the fourth encoding falls back to the plain sum
  typedef enum logic [1:0] {
    FUSE_SUM     = 2'd0,
    FUSE_MEDIAN  = 2'd1,
    FUSE_CLIP    = 2'd2,
    FUSE_SUM_ALT = 2'd3
  } fuse_mode_e;

endpackage

// File: rtl/pn_corr_phase_bank.sv
`timescale 1ns/1ps
// Interleaved branch accumulators: sample i of a window lands in branch i mod N_PH,
// weighted by chip i of the stored code.
module pn_corr_phase_bank #(
  parameter int N_PH    = 4,
  parameter int TAPS_PH = 8,
  parameter int SAMP_W  = 8,
  parameter int ACC_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic signed [SAMP_W-1:0]  in_sample,
  input  logic                      code_load,
  input  logic [N_PH*TAPS_PH-1:0]   code_word,
  output logic                      part_valid,
  output logic [N_PH*ACC_W-1:0]     part_flat
);

  localparam int WIN   = N_PH * TAPS_PH;
  localparam int IDX_W = $clog2(WIN);
  localparam int PH_W  = $clog2(N_PH);

  logic [WIN-1:0]           code_q, code_d;
  logic [IDX_W-1:0]         idx_q, idx_d;
  logic                     pv_q, pv_d;
  logic signed [ACC_W-1:0]  samp_x;
  logic signed [ACC_W-1:0]  contrib;
  logic                     win_last;

  always_comb begin
    samp_x   = {{(ACC_W-SAMP_W){in_sample[SAMP_W-1]}}, in_sample};
    contrib  = code_q[idx_q] ? samp_x : -samp_x;
    win_last = (idx_q == IDX_W'(WIN-1));
    code_d   = code_load ? code_word : code_q;
    idx_d    = idx_q;
    if (in_valid) begin
      idx_d = win_last ? '0 : idx_q + 1'b1;
    end
    pv_d = in_valid & win_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      idx_q  <= '0;
      pv_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      idx_q  <= idx_d;
      pv_q   <= pv_d;
    end
  end

  generate
    for (genvar p = 0; p < N_PH; p++) begin : g_branch
      logic signed [ACC_W-1:0] acc_q, acc_d, acc_nx;
      logic signed [ACC_W-1:0] part_q, part_d;
      logic                    hit;

      always_comb begin
        hit    = (idx_q[PH_W-1:0] == PH_W'(p));
        acc_nx = acc_q + (hit ? contrib : '0);
        acc_d  = acc_q;
        part_d = part_q;
        if (in_valid) begin
          acc_d = win_last ? '0 : acc_nx;
          if (win_last) begin
            part_d = acc_nx;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q  <= '0;
          part_q <= '0;
        end else begin
          acc_q  <= acc_d;
          part_q <= part_d;
        end
      end

      assign part_flat[p*ACC_W +: ACC_W] = part_q;
    end
  endgenerate

  assign part_valid = pv_q;

endmodule

// File: rtl/pn_corr_sort4.sv
`timescale 1ns/1ps
// Compare-exchange network for four signed values; only the two middle ranks leave.
module pn_corr_sort4 #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic signed [W-1:0] c,
  input  logic signed [W-1:0] d,
  output logic signed [W-1:0] mid_lo,
  output logic signed [W-1:0] mid_hi
);

  logic signed [W-1:0] l_ab, h_ab, l_cd, h_cd, x_lo, x_hi;

  always_comb begin
    l_ab = (a < b) ? a : b;
    h_ab = (a < b) ? b : a;
    l_cd = (c < d) ? c : d;
    h_cd = (c < d) ? d : c;
    // larger of the two minima and smaller of the two maxima are the middle pair
    x_lo = (l_ab < l_cd) ? l_cd : l_ab;
    x_hi = (h_ab < h_cd) ? h_ab : h_cd;
    mid_lo = (x_lo < x_hi) ? x_lo : x_hi;
    mid_hi = (x_lo < x_hi) ? x_hi : x_lo;
  end

endmodule

// File: rtl/pn_corr_fuse.sv
`timescale 1ns/1ps
// Three-stage fusion: sort, clip residuals, select rule and threshold.
// The sorting network fixes the branch count at four.
module pn_corr_fuse
  import pn_corr_pkg::*;
#(
  parameter int N_PH  = 4,
  parameter int ACC_W = 16,
  parameter int OUT_W = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    part_valid,
  input  logic [N_PH*ACC_W-1:0]   part_flat,
  input  fuse_mode_e              mode,
  input  logic [ACC_W-1:0]        clip_k,
  input  logic [OUT_W-1:0]        thr,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] fused,
  output logic                    detect
);

  localparam int SUM_W  = ACC_W + $clog2(N_PH);
  localparam int MED_W  = ACC_W + 1;
  localparam int RES_W  = ACC_W + 3;
  localparam int CS_W   = RES_W + $clog2(N_PH);
  localparam int WIDE_W = OUT_W + 3;

  // ---------------- stage 1: unpack, sort, total ----------------
  logic signed [ACC_W-1:0] y_in [N_PH];
  logic signed [ACC_W-1:0] mlo_d, mhi_d;
  logic signed [SUM_W-1:0] tot1_d;

  for (genvar p = 0; p < N_PH; p++) begin : g_unpack
    assign y_in[p] = part_flat[p*ACC_W +: ACC_W];
  end

  pn_corr_sort4 #(.W(ACC_W)) sort_i (
    .a      (y_in[0]),
    .b      (y_in[1]),
    .c      (y_in[2]),
    .d      (y_in[3]),
    .mid_lo (mlo_d),
    .mid_hi (mhi_d)
  );

  always_comb begin
    tot1_d = '0;
    for (int p = 0; p < N_PH; p++) begin
      tot1_d = tot1_d + SUM_W'(y_in[p]);
    end
  end

  logic signed [ACC_W-1:0] y1_q [N_PH];
  logic signed [ACC_W-1:0] mlo1_q, mhi1_q;
  logic signed [SUM_W-1:0] tot1_q;
  logic                    v1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N_PH; p++) y1_q[p] <= '0;
      mlo1_q <= '0;
      mhi1_q <= '0;
      tot1_q <= '0;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= part_valid;
      if (part_valid) begin
        for (int p = 0; p < N_PH; p++) y1_q[p] <= y_in[p];
        mlo1_q <= mlo_d;
        mhi1_q <= mhi_d;
        tot1_q <= tot1_d;
      end
    end
  end

  // ---------------- stage 2: doubled median, clipped residuals ----------------
  logic signed [MED_W-1:0] s2_d;
  logic signed [RES_W-1:0] lim2;
  logic signed [RES_W-1:0] res_v, clp_v;
  logic signed [CS_W-1:0]  cs2_d;

  always_comb begin
    s2_d  = MED_W'(mlo1_q) + MED_W'(mhi1_q);
    lim2  = RES_W'({1'b0, clip_k, 1'b0});
    cs2_d = '0;
    res_v = '0;
    clp_v = '0;
    for (int p = 0; p < N_PH; p++) begin
      res_v = (RES_W'(y1_q[p]) <<< 1) - RES_W'(s2_d);
      if (res_v > lim2) begin
        clp_v = lim2;
      end else if (res_v < -lim2) begin
        clp_v = -lim2;
      end else begin
        clp_v = res_v;
      end
      cs2_d = cs2_d + CS_W'(clp_v);
    end
  end

  logic signed [MED_W-1:0] s2_q;
  logic signed [CS_W-1:0]  cs2_q;
  logic signed [SUM_W-1:0] tot2_q;
  logic                    v2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_q   <= '0;
      cs2_q  <= '0;
      tot2_q <= '0;
      v2_q   <= 1'b0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        s2_q   <= s2_d;
        cs2_q  <= cs2_d;
        tot2_q <= tot1_q;
      end
    end
  end

  // ---------------- stage 3: rule select and threshold ----------------
  logic signed [WIDE_W-1:0] med_w, sum_w, clip_w, pick_w;
  logic signed [OUT_W-1:0]  fused_d;
  logic [OUT_W-1:0]         mag;
  logic                     det_d;

  always_comb begin
    med_w  = WIDE_W'(s2_q) <<< 1;
    sum_w  = WIDE_W'(tot2_q);
    clip_w = med_w + (WIDE_W'(cs2_q) >>> 1);
    case (mode)
      FUSE_MEDIAN: pick_w = med_w;
      FUSE_CLIP:   pick_w = clip_w;
      default:     pick_w = sum_w;
    endcase
    fused_d = pick_w[OUT_W-1:0];
    mag     = fused_d[OUT_W-1] ? OUT_W'(-fused_d) : OUT_W'(fused_d);
    det_d   = v2_q && (mag >= thr);
  end

  logic signed [OUT_W-1:0] fused_q;
  logic                    det_q;
  logic                    v3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fused_q <= '0;
      det_q   <= 1'b0;
      v3_q    <= 1'b0;
    end else begin
      v3_q  <= v2_q;
      det_q <= det_d;
      if (v2_q) begin
        fused_q <= fused_d;
      end
    end
  end

  assign out_valid = v3_q;
  assign fused     = fused_q;
  assign detect    = det_q;

endmodule

// File: rtl/pn_robust_correlator.sv
`timescale 1ns/1ps
module pn_robust_correlator
  import pn_corr_pkg::*;
#(
  parameter int N_PH    = 4,
  parameter int TAPS_PH = 8,
  parameter int SAMP_W  = 8,
  parameter int ACC_W   = 16,
  localparam int WIN    = N_PH * TAPS_PH,
  localparam int OUT_W  = ACC_W + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [SAMP_W-1:0] in_sample,
  input  logic                    code_load,
  input  logic [WIN-1:0]          code_word,
  input  logic [1:0]              fuse_mode,
  input  logic [ACC_W-1:0]        clip_k,
  input  logic [OUT_W-1:0]        det_thresh,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_corr,
  output logic                    out_detect
);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rsync_q[1];

  logic                  part_valid;
  logic [N_PH*ACC_W-1:0] part_flat;

  pn_corr_phase_bank #(
    .N_PH    (N_PH),
    .TAPS_PH (TAPS_PH),
    .SAMP_W  (SAMP_W),
    .ACC_W   (ACC_W)
  ) bank_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .code_load  (code_load),
    .code_word  (code_word),
    .part_valid (part_valid),
    .part_flat  (part_flat)
  );

  pn_corr_fuse #(
    .N_PH  (N_PH),
    .ACC_W (ACC_W),
    .OUT_W (OUT_W)
  ) fuse_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .part_valid (part_valid),
    .part_flat  (part_flat),
    .mode       (fuse_mode_e'(fuse_mode)),
    .clip_k     (clip_k),
    .thr        (det_thresh),
    .out_valid  (out_valid),
    .fused      (out_corr),
    .detect     (out_detect)
  );

endmodule

// File: rtl/pn_corr_checker.sv
`timescale 1ns/1ps
module pn_corr_checker #(
  parameter int OUT_W = 19
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    part_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_corr,
  input logic                    out_detect,
  input logic [1:0]              fuse_mode,
  input logic [OUT_W-1:0]        det_thresh
);

  logic [OUT_W-1:0] corr_mag;
  assign corr_mag = out_corr[OUT_W-1] ? OUT_W'(-out_corr) : OUT_W'(out_corr);

  // R4: a result follows the branch snapshot by three edges
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(part_valid, 3));

  // R4: results are single-cycle strobes
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8: detection only alongside a result
  assert_detect_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_detect |-> out_valid);

  // R8: a result whose magnitude reaches the threshold is flagged
  assert_detect_reaches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (corr_mag >= det_thresh)) |-> out_detect);

  // R9: value held between results
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_corr));

  // R6: median rule output is twice an integer
  assert_median_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fuse_mode == 2'd1) |-> (out_corr[0] == 1'b0));

endmodule

bind pn_robust_correlator pn_corr_checker #(.OUT_W(OUT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .part_valid (part_valid),
  .out_valid  (out_valid),
  .out_corr   (out_corr),
  .out_detect (out_detect),
  .fuse_mode  (fuse_mode),
  .det_thresh (det_thresh)
);

// File: tb/pn_robust_correlator_tb.sv
`timescale 1ns/1ps
module pn_robust_correlator_tb_top;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic signed [7:0]  in_sample;
  logic               code_load;
  logic [31:0]        code_word;
  logic [1:0]         fuse_mode;
  logic [15:0]        clip_k;
  logic [18:0]        det_thresh;
  logic               out_valid;
  logic signed [18:0] out_corr;
  logic               out_detect;

  pn_robust_correlator dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .code_load  (code_load),
    .code_word  (code_word),
    .fuse_mode  (fuse_mode),
    .clip_k     (clip_k),
    .det_thresh (det_thresh),
    .out_valid  (out_valid),
    .out_corr   (out_corr),
    .out_detect (out_detect)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int    f;
    bit    d;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t e_mon;
  int   total = 0;
  int   bad   = 0;
  int   last_f = 0;
  bit   started = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model from the requirements
  function automatic void model(input int s[32], input logic [31:0] ca, input logic [31:0] cb,
                                input int sw, input int mode, input int k, input int thr,
                                output int f, output bit d);
    int y[4];
    int srt[4];
    int sm, cs, r, t, mag;
    for (int p = 0; p < 4; p++) y[p] = 0;
    for (int i = 0; i < 32; i++) begin
      bit chip;
      chip = (sw >= 0 && i >= sw) ? cb[i] : ca[i];
      y[i % 4] += chip ? s[i] : -s[i];
    end
    for (int p = 0; p < 4; p++) srt[p] = y[p];
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3 - a; b++)
        if (srt[b] > srt[b+1]) begin t = srt[b]; srt[b] = srt[b+1]; srt[b+1] = t; end
    sm = srt[1] + srt[2];
    cs = 0;
    for (int p = 0; p < 4; p++) begin
      r = 2 * y[p] - sm;
      if (r > 2 * k) r = 2 * k;
      else if (r < -2 * k) r = -2 * k;
      cs += r;
    end
    case (mode)
      1:       f = 2 * sm;
      2:       f = 2 * sm + (cs >>> 1);
      default: f = y[0] + y[1] + y[2] + y[3];
    endcase
    mag = (f < 0) ? -f : f;
    d = (mag >= thr);
  endfunction

  // driver: pushes the expected item, feeds one window, checks the strobe timing (R4)
  task automatic run_win(input int s[32], input bit do_load, input logic [31:0] ca,
                         input logic [31:0] cb, input int sw, input int mode, input int k,
                         input int thr, input int gap, input string tag);
    int  f;
    bit  d;
    exp_t it;
    model(s, ca, cb, sw, mode, k, thr, f, d);
    it.f = f; it.d = d; it.tag = tag;
    exp_q.push_back(it);
    fuse_mode  = 2'(mode);
    clip_k     = 16'(k);
    det_thresh = 19'(thr);
    if (do_load) begin
      code_word = ca; code_load = 1'b1; in_valid = 1'b0;
      @(negedge clk);
      code_load = 1'b0;
    end
    for (int i = 0; i < 32; i++) begin
      if (i == sw) begin
        code_word = cb; code_load = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        code_load = 1'b0;
      end
      in_valid  = 1'b1;
      in_sample = 8'(s[i]);
      @(negedge clk);
      if (gap > 0 && i < 31) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R4 early strobe edge1", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 early strobe edge2", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 early strobe edge3", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R4 strobe on third edge", int'(out_valid), 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 strobe one cycle", int'(out_valid), 0);
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (started && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected result", 1, 0);
      end else begin
        e_mon = exp_q.pop_front();
        chk(int'(out_corr) == e_mon.f, {e_mon.tag, " out_corr"}, int'(out_corr), e_mon.f);
        chk(out_detect == e_mon.d, {"R8 ", e_mon.tag, " out_detect"}, int'(out_detect), int'(e_mon.d));
        last_f = e_mon.f;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R4 watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s[32];
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; code_load = 1'b0;
    code_word = '0; fuse_mode = '0; clip_k = '0; det_thresh = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(out_detect == 1'b0, "R1 out_detect in reset", int'(out_detect), 0);
    chk(out_corr == '0, "R1 out_corr in reset", int'(out_corr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && out_corr == '0, "R1 after release", int'(out_corr), 0);
    started = 1'b1;

    // R1 R2: reset code is all -1 chips: constant +5 gives -40 per branch
    for (int i = 0; i < 32; i++) s[i] = 5;
    run_win(s, 1'b0, 32'h0, 32'h0, -1, 0, 0, 100, 0, "R1 R2 reset code");

    // R5 R8: all +1 chips, equal threshold detects
    for (int i = 0; i < 32; i++) s[i] = 10;
    run_win(s, 1'b1, 32'hFFFF_FFFF, 32'h0, -1, 0, 0, 320, 0, "R5 constant sum");
    // R6 R8: one above the magnitude, no detect
    run_win(s, 1'b0, 32'hFFFF_FFFF, 32'h0, -1, 1, 0, 321, 0, "R6 constant median");

    // outlier on branch 2 only
    for (int i = 0; i < 32; i++) s[i] = (i % 4 == 2) ? 100 : 10;
    run_win(s, 1'b0, 32'hFFFF_FFFF, 32'h0, -1, 0, 0, 1000, 0, "R5 outlier sum");
    run_win(s, 1'b0, 32'hFFFF_FFFF, 32'h0, -1, 3, 0, 2000, 0, "R5 outlier sum mode3");
    run_win(s, 1'b0, 32'hFFFF_FFFF, 32'h0, -1, 1, 0, 321, 0, "R6 outlier median");
    run_win(s, 1'b0, 32'hFFFF_FFFF, 32'h0, -1, 2, 5, 325, 0, "R7 outlier clipped");
    run_win(s, 1'b0, 32'hFFFF_FFFF, 32'h0, -1, 2, 0, 320, 0, "R10 clip zero equals median");

    // R3 R7: random data, codes, limits and gaps
    for (int r = 0; r < 9; r++) begin
      logic [31:0] cr;
      cr = $urandom();
      for (int i = 0; i < 32; i++) s[i] = int'($urandom_range(255)) - 128;
      run_win(s, 1'b1, cr, 32'h0, -1, r % 3, int'($urandom_range(300)),
              int'($urandom_range(1500)), r % 3, "R3 R7 random");
    end

    // R2: code reload in mid-window
    for (int i = 0; i < 32; i++) s[i] = (i * 7 % 23) - 11;
    run_win(s, 1'b1, 32'hA5A5_0F0F, 32'h3C3C_F00F, 16, 0, 0, 50, 0, "R2 mid-window reload sum");
    run_win(s, 1'b1, 32'h1234_5678, 32'hFEDC_BA98, 9, 2, 7, 50, 1, "R2 mid-window reload clipped");

    // R9: held value after the last result
    repeat (10) @(negedge clk);
    chk(int'(out_corr) == last_f, "R9 held value", int'(out_corr), last_f);
    chk(out_detect == 1'b0, "R8 detect idle", int'(out_detect), 0);
    chk(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule